// File: doc/BRIEF.md
# Frame-Slotted Correction Output Scheduler

This block decides when corrected packet data is handed to a host and raises one interrupt pulse for every packet it hands over. An upstream block synchronizer supplies a block pulse for every received block and a frame pulse together with the block pulse that opens a frame. From these pulses the scheduler tracks the position of the current block inside a frame of 272 received blocks. It emits two kinds of output. The first is an immediate output of each horizontally corrected packet, released while the next block is being received. The second is a delayed output of vertically corrected data blocks from the previous frame. Each of these is locked to a fixed slot in the current frame.

The upstream correction logic reports, through a flag-write port, which of the 190 data blocks it fully corrected during the current frame. At the next frame start those flags become a snapshot. A flagged block gets no vertical output, and its slot stays empty: later blocks are never pulled forward into the gap. Vertical output for a frame is allowed only if the previous frame was tracked from start to end under frame sync and left at least one block uncorrected. A loss of frame sync cancels all pending vertical work and leaves the block unframed until the next frame pulse.

The block only produces timing, tags and indices. The data itself, the correction arithmetic and the memories sit elsewhere.

Top module: `corr_out_sched`

## Requirements
- R1: A block pulse that comes with a frame pulse while frame_sync is high sets the block position to 1. Each later block pulse advances the position by one. A block pulse that arrives at position 272 without a frame pulse leaves the block unframed. While unframed, no interrupt is produced until the next frame start.
- R2: On each block pulse while framed and in sync, the block releases the packet just finished, with irq_vert=0 and irq_idx equal to the previous position (1 to 272). The irq output goes high in the cycle that begins INT_DELAY clock edges after the edge that sampled the block pulse.
- R3: Vertical output for data block k (1 to 190) occurs in the slot of received block 28+k, with irq_vert=1 and irq_idx=k. Its irq goes high INT_DELAY+VERT_GAP edges after the edge that sampled that block pulse.
- R4: Vertical output in a frame is enabled only if three conditions hold. The previous frame started under sync. It reached position 272 without a sync loss. At least one of its 190 data flags stayed clear. In the first frame after reset, no vertical output occurs.
- R5: A fix_valid pulse with fix_idx in 1 to 190 marks that data block while framed. Indices of 0 or above 190 are ignored. A write in the frame-start cycle belongs to the new frame. A block marked in frame n gets no vertical output or interrupt in frame n+1. The slots of other blocks do not move: if blocks 1 to 100 are marked, block 101 still goes out at received block 129.
- R6: While frame_sync is low, a pending vertical output is cancelled, the block becomes unframed, and vertical output stays disabled for the following frame. No horizontal output is released while unframed.
- R7: Every interrupt is a single-cycle pulse. In every cycle other than the scheduled horizontal and vertical slots after a block pulse, irq stays low.
- R8: After reset, irq is low and no output is produced before the first frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_pulse | input | 1 | One-cycle pulse per received block |
| frm_pulse | input | 1 | Frame start marker, valid together with blk_pulse |
| frame_sync | input | 1 | High while frame synchronization holds |
| fix_valid | input | 1 | Write strobe for a fully-corrected flag |
| fix_idx | input | 8 | Data block number (1 to 190) to mark |
| irq | output | 1 | Single-cycle interrupt per released packet |
| irq_vert | output | 1 | 0 for horizontal output, 1 for vertical output; valid with irq |
| irq_idx | output | 9 | Packet number of the release; valid with irq |

## Verification
The bench drives whole frames with four flag patterns. Random flags show that gaps are left where blocks are marked. No flags show that every slot from 29 to 218 fires. The first 100 flags show that the first vertical release stays at block 129 rather than moving forward. Flags on all 190 blocks show that vertical output is disabled completely. Out-of-range flag indices show that writes are ignored. A sync drop between the horizontal and vertical pulses of one block separates the cancellation of a pending release from ordinary scheduling. An extra block past position 272 without a frame pulse, and the frame that follows a broken frame, show that tracking really ends and that vertical output is withheld.

// File: rtl/corr_out_pkg.sv
package corr_out_pkg;
    typedef enum logic {
        TAG_HORZ = 1'b0,
        TAG_VERT = 1'b1
    } out_tag_e;
endpackage

// File: rtl/cos_frame_track.sv
module cos_frame_track #(
    parameter int FB = 272,
    parameter int BW = $clog2(FB + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bck,
    input  logic          fck,
    input  logic          sync,
    input  logic          all_fixed,
    output logic [BW-1:0] blk_o,
    output logic [BW-1:0] blk_next_o,
    output logic          ven_next_o,
    output logic          start_o,
    output logic          framed_o
);
    localparam logic [BW-1:0] LAST = BW'(FB);

    typedef struct packed {
        logic [BW-1:0] blk;
        logic          ven;
        logic          ok;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        start_o = bck && fck && sync;
        if (!sync) begin
            st_d.blk = '0;
            st_d.ven = 1'b0;
            st_d.ok  = 1'b0;
        end else if (start_o) begin
            st_d.ven = st_q.ok && (st_q.blk == LAST) && !all_fixed;
            st_d.ok  = 1'b1;
            st_d.blk = BW'(1);
        end else if (bck && st_q.blk != '0) begin
            st_d.blk = (st_q.blk == LAST) ? '0 : st_q.blk + BW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign blk_o      = st_q.blk;
    assign blk_next_o = st_d.blk;
    assign ven_next_o = st_d.ven;
    assign framed_o   = (st_q.blk != '0) && sync;

    assert_frame_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bck && fck && sync) |=> (st_q.blk == BW'(1)));

    assert_sync_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sync |=> (st_q.blk == '0 && !st_q.ven));

    assert_ven_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ven) |-> $past(bck && fck && sync));
endmodule

// File: rtl/cos_flag_store.sv
module cos_flag_store #(
    parameter int DB = 190,
    parameter int IW = $clog2(DB + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          framed,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_fixed,
    output logic          all_fixed
);
    typedef struct packed {
        logic [DB-1:0] cur;
        logic [DB-1:0] snap;
    } fl_t;

    fl_t fl_d, fl_q;
    logic wr_ok;
    logic rd_ok;

    always_comb begin
        fl_d  = fl_q;
        wr_ok = wr_en && framed && (wr_idx != '0) && (wr_idx <= IW'(DB));
        if (start) begin
            fl_d.snap = fl_q.cur;
            fl_d.cur  = '0;
        end
        if (wr_ok) fl_d.cur[wr_idx - IW'(1)] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign rd_ok     = (rd_idx != '0) && (rd_idx <= IW'(DB));
    assign rd_fixed  = rd_ok ? fl_q.snap[rd_idx - IW'(1)] : 1'b1;
    assign all_fixed = &fl_q.cur;
endmodule

// File: rtl/cos_irq_gen.sv
module cos_irq_gen #(
    parameter int BW        = 9,
    parameter int INT_DELAY = 2,
    parameter int VERT_GAP  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bck,
    input  logic          cancel,
    input  logic          h_req,
    input  logic [BW-1:0] h_idx,
    input  logic          v_req,
    input  logic [BW-1:0] v_idx,
    output logic          irq,
    output logic          irq_vert,
    output logic [BW-1:0] irq_idx
);
    import corr_out_pkg::*;

    localparam int CMAX = INT_DELAY + VERT_GAP;
    localparam int CW   = $clog2(CMAX + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ph;
        logic          pv;
        logic [BW-1:0] hidx;
        logic [BW-1:0] vidx;
        logic          irq;
        out_tag_e      tag;
        logic [BW-1:0] oidx;
    } ig_t;

    ig_t ig_d, ig_q;

    always_comb begin
        ig_d     = ig_q;
        ig_d.irq = 1'b0;
        if (bck) begin
            ig_d.cnt  = '0;
            ig_d.ph   = h_req;
            ig_d.pv   = v_req;
            ig_d.hidx = h_idx;
            ig_d.vidx = v_idx;
        end else begin
            if (ig_q.cnt < CW'(CMAX)) ig_d.cnt = ig_q.cnt + CW'(1);
            if (ig_q.ph && ig_q.cnt == CW'(INT_DELAY - 1)) begin
                ig_d.irq  = 1'b1;
                ig_d.tag  = TAG_HORZ;
                ig_d.oidx = ig_q.hidx;
                ig_d.ph   = 1'b0;
            end else if (ig_q.pv && ig_q.cnt == CW'(CMAX - 1)) begin
                ig_d.irq  = 1'b1;
                ig_d.tag  = TAG_VERT;
                ig_d.oidx = ig_q.vidx;
                ig_d.pv   = 1'b0;
            end
            if (cancel) ig_d.pv = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ig_q <= '0;
        else        ig_q <= ig_d;
    end

    assign irq      = ig_q.irq;
    assign irq_vert = (ig_q.tag == TAG_VERT);
    assign irq_idx  = ig_q.oidx;

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_no_irq_after_bck_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bck |=> !irq);
endmodule

// File: rtl/corr_out_sched.sv
module corr_out_sched #(
    parameter int FRAME_BLOCKS = 272,
    parameter int DATA_BLOCKS  = 190,
    parameter int VERT_OFFSET  = 28,
    parameter int INT_DELAY    = 2,
    parameter int VERT_GAP     = 3,
    parameter int IW           = $clog2(DATA_BLOCKS + 1),
    parameter int BW           = $clog2(FRAME_BLOCKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blk_pulse,
    input  logic          frm_pulse,
    input  logic          frame_sync,
    input  logic          fix_valid,
    input  logic [IW-1:0] fix_idx,
    output logic          irq,
    output logic          irq_vert,
    output logic [BW-1:0] irq_idx
);
    localparam logic [BW-1:0] WIN_LO = BW'(VERT_OFFSET + 1);
    localparam logic [BW-1:0] WIN_HI = BW'(VERT_OFFSET + DATA_BLOCKS);

    logic [BW-1:0] blk, blk_next, k_full;
    logic          ven_next, start, framed, all_fixed, rd_fixed;
    logic          in_win, h_req, v_req;
    logic [IW-1:0] k_idx;

    cos_frame_track #(.FB(FRAME_BLOCKS), .BW(BW)) u_track (
        .clk(clk), .rst_n(rst_n), .bck(blk_pulse), .fck(frm_pulse),
        .sync(frame_sync), .all_fixed(all_fixed), .blk_o(blk),
        .blk_next_o(blk_next), .ven_next_o(ven_next), .start_o(start),
        .framed_o(framed)
    );

    always_comb begin
        in_win = (blk_next >= WIN_LO) && (blk_next <= WIN_HI);
        k_full = in_win ? (blk_next - BW'(VERT_OFFSET)) : '0;
        k_idx  = IW'(k_full);
        h_req  = blk_pulse && frame_sync && (blk != '0);
        v_req  = blk_pulse && ven_next && in_win && !rd_fixed;
    end

    cos_flag_store #(.DB(DATA_BLOCKS), .IW(IW)) u_flags (
        .clk(clk), .rst_n(rst_n), .start(start), .framed(framed),
        .wr_en(fix_valid), .wr_idx(fix_idx), .rd_idx(k_idx),
        .rd_fixed(rd_fixed), .all_fixed(all_fixed)
    );

    cos_irq_gen #(.BW(BW), .INT_DELAY(INT_DELAY), .VERT_GAP(VERT_GAP)) u_irq (
        .clk(clk), .rst_n(rst_n), .bck(blk_pulse), .cancel(!frame_sync),
        .h_req(h_req), .h_idx(blk), .v_req(v_req), .v_idx(k_full),
        .irq(irq), .irq_vert(irq_vert), .irq_idx(irq_idx)
    );

    assert_vert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_vert) |-> (irq_idx >= BW'(1) && irq_idx <= BW'(DATA_BLOCKS)));

    assert_horz_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_vert) |-> (irq_idx >= BW'(1) && irq_idx <= BW'(FRAME_BLOCKS)));
endmodule

// File: tb/corr_out_sched_tb.sv
module corr_out_sched_tb;
    localparam int D   = 2;
    localparam int G   = 3;
    localparam int GAP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       blk_pulse = 1'b0, frm_pulse = 1'b0, frame_sync = 1'b1;
    logic       fix_valid = 1'b0;
    logic [7:0] fix_idx = '0;
    logic       irq, irq_vert;
    logic [8:0] irq_idx;

    int errors = 0, checks = 0;
    bit done = 0;

    int m_blk = 0;
    bit m_ven = 0, m_ok = 0;
    bit m_cur [1:190];
    bit m_snap[1:190];

    always #2 clk = ~clk;

    corr_out_sched u_dut (
        .clk(clk), .rst_n(rst_n), .blk_pulse(blk_pulse), .frm_pulse(frm_pulse),
        .frame_sync(frame_sync), .fix_valid(fix_valid), .fix_idx(fix_idx),
        .irq(irq), .irq_vert(irq_vert), .irq_idx(irq_idx)
    );

    function automatic bit all_fixed();
        for (int i = 1; i <= 190; i++) if (!m_cur[i]) return 0;
        return 1;
    endfunction

    task automatic check_slot(input string tag, input int j, input bit e_irq,
                              input bit e_vert, input int e_idx);
        checks++;
        if (irq !== e_irq || (e_irq && (irq_vert !== e_vert || irq_idx != 9'(e_idx)))) begin
            errors++;
            $display("FAIL %s slot %0d: irq=%0b vert=%0b idx=%0d expected irq=%0b vert=%0b idx=%0d",
                     tag, j, irq, irq_vert, irq_idx, e_irq, e_vert, e_idx);
        end
    endtask

    task automatic send_block(input bit f, input int fixv, input bit drop, input string vtag);
        bit eh, ev;
        int hidx, vidx;
        eh = (m_blk != 0);
        hidx = m_blk;
        if (f) begin
            m_ven = m_ok && (m_blk == 272) && !all_fixed();
            for (int i = 1; i <= 190; i++) begin m_snap[i] = m_cur[i]; m_cur[i] = 0; end
            m_ok = 1;
            m_blk = 1;
        end else if (m_blk != 0) begin
            m_blk = (m_blk == 272) ? 0 : m_blk + 1;
        end
        ev = m_ven && m_blk >= 29 && m_blk <= 218 && !m_snap[m_blk - 28];
        vidx = m_blk - 28;
        if (fixv >= 1 && fixv <= 190 && m_blk != 0) m_cur[fixv] = 1;
        if (drop) begin ev = 0; m_blk = 0; m_ven = 0; m_ok = 0; end

        @(negedge clk);
        blk_pulse = 1'b1;
        frm_pulse = f;
        @(posedge clk);
        @(negedge clk);
        blk_pulse = 1'b0;
        frm_pulse = 1'b0;
        if (fixv >= 0) begin fix_valid = 1'b1; fix_idx = 8'(fixv); end
        for (int j = 1; j <= GAP; j++) begin
            @(posedge clk);
            @(negedge clk);
            if (j == 1) fix_valid = 1'b0;
            if (drop && j == D) frame_sync = 1'b0;
            if (drop && j == D + 1) frame_sync = 1'b1;
            if (j == D)          check_slot("R2", j, eh, 1'b0, hidx);
            else if (j == D + G) check_slot(vtag, j, ev, 1'b1, vidx);
            else                 check_slot("R7", j, 1'b0, 1'b0, 0);
        end
    endtask

    // mode 0 random flags, 1 all data flags, 2 flags 1..100, 3 none
    task automatic run_frame(input int mode, input int drop_at, input string vtag);
        for (int b = 1; b <= 272; b++) begin
            int fv;
            fv = -1;
            case (mode)
                0: if (b <= 190 && ($urandom % 2) == 1) fv = b;
                   else if (b > 190 && b <= 200) fv = b;
                1: if (b <= 190) fv = b;
                2: if (b <= 100) fv = b;
                default: fv = -1;
            endcase
            if (mode == 0 && b == 201) fv = 0;
            send_block(b == 1, fv, b == drop_at, vtag);
        end
    endtask

    initial begin
        void'($urandom(32'd1357));
        for (int i = 1; i <= 190; i++) begin m_cur[i] = 0; m_snap[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (irq !== 1'b0) begin
            errors++;
            $display("FAIL R8: irq=%0b expected 0 during reset", irq);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (irq !== 1'b0) begin
            errors++;
            $display("FAIL R8: irq=%0b expected 0 after reset", irq);
        end
        for (int i = 0; i < 3; i++) send_block(1'b0, -1, 1'b0, "R8");
        run_frame(0, 0, "R4");
        run_frame(2, 0, "R3");
        run_frame(1, 0, "R5");
        run_frame(3, 0, "R4");
        run_frame(0, 60, "R6");
        run_frame(0, 0, "R6");
        run_frame(3, 0, "R3");
        run_frame(0, 0, "R5");
        send_block(1'b0, -1, 1'b0, "R1");
        send_block(1'b0, -1, 1'b0, "R1");
        send_block(1'b0, 5, 1'b0, "R1");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule